// File: doc/BRIEF.md
# Timer compare-match interrupt status unit

This block is one timer channel. It holds a counter, three compare values (A, B and A2) and a mode state machine. Each cycle the running counter is compared against the compare values. A hit sets a sticky status flag, but only when the current mode allows that flag. Software clears a flag by writing a 0 to its bit. A 1 written to a bit leaves that bit unchanged. The interrupt line is high while any implemented flag is set.

The channel has four states. `ST_STOP` (mode code 0) holds the counter. `ST_INTERVAL` (code 1) counts up and returns to zero after the count equals compare A. `ST_PULSE` (code 2) and `ST_WDOG` (code 3) count up freely and wrap at the counter width. A write to the mode register is the only transition. It moves the machine from any state to the state whose code was written, and it restarts the counter at zero.

The `CHAN` parameter (0, 1 or 2) selects both the address window and the set of flags that exist. Three copies of the block give the three channels. A flag that does not exist reads 0 and is never set.

Top module: `tmr_match_stat`

## Requirements
- R1: Flag bit 0 is set on the clock edge where the counter equals compare A while the state is `ST_INTERVAL`. No other state sets it.
- R2: Flag bit 1 is set on a compare-A hit and flag bit 2 on a compare-B hit, only in state `ST_PULSE`.
- R3: Flag bit 3 is set on a compare-A2 hit, only in state `ST_WDOG`.
- R4: A write to the status register clears every implemented flag whose data bit is 0. A data bit of 1 leaves its flag unchanged.
- R5: Reset clears all flags, the compare values, the counter and the state (to `ST_STOP`). Status bits 31 to 4 always read 0.
- R6: In channels 0 and 1, bit 3 does not exist. In channel 2, bits 1 and 2 do not exist. A bit that does not exist reads 0 and never sets.
- R7: The register window starts at 0xF000 + 0x100·CHAN. The offsets are: mode at +0x00 (bits 1:0), status at +0x04, compare A at +0x08, compare B at +0x0C, compare A2 at +0x10, and the counter at +0x14 (read-only). Any other address reads 0.
- R8: If a hit and a clearing write reach the same flag in the same cycle, the flag ends set.
- R9: `irq_o` is high exactly when at least one flag is set. `stat_o` shows the flags.
- R10: In `ST_INTERVAL`, the counter runs 0, 1, … A, 0. A mode write resets the counter to 0. In `ST_STOP` the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| stat_o | output | 4 | Status flags |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that each flag rises only after a hit in its own mode. They also check that a 0 written to a flag clears it unless a hit arrives in that cycle, that a written 1 never clears a set flag, that a hit always wins over a clear, that the interval counter wraps to 0, and that the reserved status bits read 0. Some behaviours can be seen only in the bench's scenarios: the exact cycle at which the counter wraps and the flag sets, the per-channel flag sets compared across channels 0 and 2, address decoding between two channels on a shared bus, and reset in the middle of a run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_STOP     = 2'd0,
        ST_INTERVAL = 2'd1,
        ST_PULSE    = 2'd2,
        ST_WDOG     = 2'd3
    } chan_state_t;

    localparam int NUM_FLAGS = 4;
    localparam int NUM_CMP   = 3;

    // flag bit positions (software decodes these)
    localparam int FL_INT = 0;
    localparam int FL_PA  = 1;
    localparam int FL_PB  = 2;
    localparam int FL_WD  = 3;

    // comparator slots
    localparam int CMP_A  = 0;
    localparam int CMP_B  = 1;
    localparam int CMP_A2 = 2;

    // register offsets within a channel window
    localparam logic [15:0] OFS_MODE = 16'h0000;
    localparam logic [15:0] OFS_STAT = 16'h0004;
    localparam logic [15:0] OFS_CMPA = 16'h0008;
    localparam logic [15:0] OFS_CMPB = 16'h000C;
    localparam logic [15:0] OFS_CMPW = 16'h0010;
    localparam logic [15:0] OFS_CNT  = 16'h0014;

    localparam logic [15:0] WIN_BASE = 16'hF000;
    localparam logic [15:0] WIN_STEP = 16'h0100;

    function automatic logic [NUM_FLAGS-1:0] impl_mask(input int chan);
        if (chan == 2)
            return 4'b1001;
        else
            return 4'b0111;
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             wrap,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run) begin
            if (wrap)
                cnt <= '0;
            else
                cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
    parameter int CNT_W = 32,
    parameter int N     = 3
) (
    input  logic [CNT_W-1:0]        cnt,
    input  logic [N-1:0][CNT_W-1:0] refs,
    output logic [N-1:0]            hit
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = (cnt == refs[g]);
    end

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int                 NF   = 4,
    parameter logic [NF-1:0]      IMPL = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set_v,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_data,
    output logic [NF-1:0] flags
);

    for (genvar g = 0; g < NF; g++) begin : g_flag
        if (IMPL[g]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (set_v[g])
                    q <= 1'b1;
                else if (clr_we && !clr_data[g])
                    q <= 1'b0;
            end
            assign flags[g] = q;
        end else begin : g_rsvd
            assign flags[g] = 1'b0;
        end
    end

endmodule

// File: rtl/tmr_match_stat.sv
module tmr_match_stat
    import tmr_pkg::*;
#(
    parameter int CHAN   = 0,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [3:0]        stat_o,
    output logic              irq_o
);

    localparam logic [NUM_FLAGS-1:0] IMPL = impl_mask(CHAN);
    localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(WIN_BASE + WIN_STEP * 16'(CHAN));
    localparam logic [ADDR_W-1:0] A_MODE = BASE + ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = BASE + ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CMPA = BASE + ADDR_W'(OFS_CMPA);
    localparam logic [ADDR_W-1:0] A_CMPB = BASE + ADDR_W'(OFS_CMPB);
    localparam logic [ADDR_W-1:0] A_CMPW = BASE + ADDR_W'(OFS_CMPW);
    localparam logic [ADDR_W-1:0] A_CNT  = BASE + ADDR_W'(OFS_CNT);

    // ---------------- address decode ----------------
    logic mode_we, stat_we, cmpa_we, cmpb_we, cmpw_we, sel_stat;

    always_comb begin
        mode_we = reg_we && (reg_addr == A_MODE);
        stat_we = reg_we && (reg_addr == A_STAT);
        cmpa_we = reg_we && (reg_addr == A_CMPA);
        cmpb_we = reg_we && (reg_addr == A_CMPB);
        cmpw_we = reg_we && (reg_addr == A_CMPW);
        sel_stat = (reg_addr == A_STAT);
    end

    // ---------------- compare values ----------------
    logic [CNT_W-1:0] cmp_a, cmp_b, cmp_a2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_a  <= '0;
            cmp_b  <= '0;
            cmp_a2 <= '0;
        end else begin
            if (cmpa_we) cmp_a  <= reg_wdata[CNT_W-1:0];
            if (cmpb_we) cmp_b  <= reg_wdata[CNT_W-1:0];
            if (cmpw_we) cmp_a2 <= reg_wdata[CNT_W-1:0];
        end
    end

    // ---------------- mode state machine ----------------
    chan_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_STOP;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOP:     if (mode_we) state_nx = chan_state_t'(reg_wdata[1:0]);
            ST_INTERVAL: if (mode_we) state_nx = chan_state_t'(reg_wdata[1:0]);
            ST_PULSE:    if (mode_we) state_nx = chan_state_t'(reg_wdata[1:0]);
            ST_WDOG:     if (mode_we) state_nx = chan_state_t'(reg_wdata[1:0]);
        endcase
    end

    logic run, en_int, en_pls, en_wd;

    always_comb begin
        run    = 1'b0;
        en_int = 1'b0;
        en_pls = 1'b0;
        en_wd  = 1'b0;
        unique case (state)
            ST_STOP:     ;
            ST_INTERVAL: begin run = 1'b1; en_int = 1'b1; end
            ST_PULSE:    begin run = 1'b1; en_pls = 1'b1; end
            ST_WDOG:     begin run = 1'b1; en_wd  = 1'b1; end
        endcase
    end

    // ---------------- counter and comparators ----------------
    logic [CNT_W-1:0]               cnt;
    logic [NUM_CMP-1:0][CNT_W-1:0]  refs;
    logic [NUM_CMP-1:0]             hit;

    assign refs[CMP_A]  = cmp_a;
    assign refs[CMP_B]  = cmp_b;
    assign refs[CMP_A2] = cmp_a2;

    tmr_cmp #(.CNT_W(CNT_W), .N(NUM_CMP)) u_cmp (
        .cnt  (cnt),
        .refs (refs),
        .hit  (hit)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (mode_we),
        .run     (run),
        .wrap    (en_int && hit[CMP_A]),
        .cnt     (cnt)
    );

    // ---------------- flags ----------------
    logic [NUM_FLAGS-1:0] set_v, flags;

    always_comb begin
        set_v         = '0;
        set_v[FL_INT] = en_int && hit[CMP_A];
        set_v[FL_PA]  = en_pls && hit[CMP_A];
        set_v[FL_PB]  = en_pls && hit[CMP_B];
        set_v[FL_WD]  = en_wd  && hit[CMP_A2];
    end

    tmr_flags #(.NF(NUM_FLAGS), .IMPL(IMPL)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_v    (set_v),
        .clr_we   (stat_we),
        .clr_data (reg_wdata[NUM_FLAGS-1:0]),
        .flags    (flags)
    );

    // ---------------- read mux and outputs ----------------
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_MODE)      reg_rdata = DATA_W'(state);
        else if (sel_stat)           reg_rdata = DATA_W'(flags);
        else if (reg_addr == A_CMPA) reg_rdata = DATA_W'(cmp_a);
        else if (reg_addr == A_CMPB) reg_rdata = DATA_W'(cmp_b);
        else if (reg_addr == A_CMPW) reg_rdata = DATA_W'(cmp_a2);
        else if (reg_addr == A_CNT)  reg_rdata = DATA_W'(cnt);
    end

    assign stat_o = flags;
    assign irq_o  = |flags;

endmodule

// File: rtl/tmr_match_stat_chk.sv
module tmr_match_stat_chk #(
    parameter int          CNT_W  = 32,
    parameter int          DATA_W = 32,
    parameter logic [3:0]  IMPL   = 4'b0111
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              mode_we,
    input logic              stat_we,
    input logic [3:0]        wd,
    input logic [3:0]        set_v,
    input logic [3:0]        status,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp_a,
    input logic [CNT_W-1:0]  cmp_b,
    input logic [CNT_W-1:0]  cmp_a2,
    input logic              sel_stat,
    input logic [DATA_W-1:0] rdata
);

    p_int_rise_r1: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !$past(status[0])) |-> $past(mode == 2'd1 && cnt == cmp_a));

    p_pa_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !$past(status[1])) |-> $past(mode == 2'd2 && cnt == cmp_a));

    p_pb_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (status[2] && !$past(status[2])) |-> $past(mode == 2'd2 && cnt == cmp_b));

    p_wd_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (status[3] && !$past(status[3])) |-> $past(mode == 2'd3 && cnt == cmp_a2));

    p_zero_clears_r4: assert property (@(posedge clk) disable iff (rst)
        $past(stat_we) |-> ((status & ~$past(wd) & ~$past(set_v)) == 4'b0));

    p_one_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        $past(stat_we) |-> ((status & $past(status & wd)) == $past(status & wd)));

    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
        sel_stat |-> (rdata[DATA_W-1:4] == '0));

    p_hit_wins_r8: assert property (@(posedge clk) disable iff (rst)
        $past(stat_we) |-> ((status & $past(set_v & IMPL)) == $past(set_v & IMPL)));

    p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        $past(mode == 2'd1 && !mode_we && cnt == cmp_a) |-> (cnt == '0));

endmodule

bind tmr_match_stat tmr_match_stat_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .IMPL   (IMPL)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (state),
    .mode_we  (mode_we),
    .stat_we  (stat_we),
    .wd       (reg_wdata[3:0]),
    .set_v    (set_v),
    .status   (flags),
    .cnt      (cnt),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .cmp_a2   (cmp_a2),
    .sel_stat (sel_stat),
    .rdata    (reg_rdata)
);

// File: tb/tmr_match_stat_tb.sv
module tmr_match_stat_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] rdata0, rdata2;
    logic [3:0]  stat0, stat2;
    logic        irq0, irq2;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tmr_match_stat #(.CHAN(0)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata0), .stat_o(stat0), .irq_o(irq0)
    );

    tmr_match_stat #(.CHAN(2)) u_dut2 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata2), .stat_o(stat2), .irq_o(irq2)
    );

    // op: 0 write, 1 read-compare on u_dut, 2 idle (data = cycles)
    // fields: {req[7:0], op[1:0], addr[15:0], data[31:0], exp[31:0]}
    localparam int NV = 26;
    localparam logic [89:0] VEC [NV] = '{
        {8'd7,  2'd0, 16'hF008, 32'd5,        32'd0},  // R7 compare A
        {8'd7,  2'd0, 16'hF00C, 32'd3,        32'd0},  // R7 compare B
        {8'd7,  2'd0, 16'hF010, 32'd7,        32'd0},  // R7 compare A2
        {8'd5,  2'd1, 16'hF004, 32'd0,        32'h0},  // R5 status idle
        {8'd1,  2'd0, 16'hF000, 32'd1,        32'd0},  // R1 interval
        {8'd1,  2'd2, 16'h0000, 32'd10,       32'd0},
        {8'd1,  2'd1, 16'hF004, 32'd0,        32'h1},  // R1 bit0 set
        {8'd10, 2'd0, 16'hF000, 32'd0,        32'd0},  // stop
        {8'd4,  2'd0, 16'hF004, 32'hFFFF_FFFF, 32'd0}, // R4 ones
        {8'd4,  2'd1, 16'hF004, 32'd0,        32'h1},  // R4 kept
        {8'd4,  2'd0, 16'hF004, 32'h0,        32'd0},
        {8'd4,  2'd1, 16'hF004, 32'd0,        32'h0},  // R4 cleared
        {8'd2,  2'd0, 16'hF000, 32'd2,        32'd0},  // R2 pulse
        {8'd2,  2'd2, 16'h0000, 32'd10,       32'd0},
        {8'd2,  2'd1, 16'hF004, 32'd0,        32'h6},  // R2 bits 1,2; R1 gated
        {8'd10, 2'd0, 16'hF000, 32'd0,        32'd0},
        {8'd4,  2'd0, 16'hF004, 32'hFFFF_FFFB, 32'd0}, // R4 clear bit2 only
        {8'd4,  2'd1, 16'hF004, 32'd0,        32'h2},
        {8'd4,  2'd0, 16'hF004, 32'h0,        32'd0},
        {8'd3,  2'd0, 16'hF000, 32'd3,        32'd0},  // R3 watchdog
        {8'd3,  2'd2, 16'h0000, 32'd12,       32'd0},
        {8'd6,  2'd1, 16'hF004, 32'd0,        32'h0},  // R6 bit3 absent ch0
        {8'd10, 2'd0, 16'hF000, 32'd0,        32'd0},
        {8'd10, 2'd1, 16'hF014, 32'd0,        32'h0},  // R10 counter restart
        {8'd7,  2'd1, 16'hF000, 32'd0,        32'h0},  // R7 mode readback
        {8'd7,  2'd1, 16'hF204, 32'd0,        32'h0}   // R7 other window
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] v0,
                      output logic [31:0] v2);
        reg_addr = a;
        #1;
        v0 = rdata0;
        v2 = rdata2;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v0, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(irq0 == 1'b0 && stat0 == 4'h0, "R5 reset irq/stat", {27'd0, irq0, stat0}, 32'h0);

        // ---------- vector table ----------
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  rq;
            logic [1:0]  op;
            logic [15:0] ad;
            logic [31:0] dt, ex;
            {rq, op, ad, dt, ex} = VEC[i];
            if (op == 2'd0) begin
                wr(ad, dt);
            end else if (op == 2'd2) begin
                repeat (dt) @(negedge clk);
            end else begin
                rd(ad, v0, v2);
                checks++;
                if (v0 !== ex) begin
                    failures++;
                    $display("FAIL R%0d vec %0d actual=%h expected=%h", rq, i, v0, ex);
                end
            end
        end

        // ---------- R10 / R1 cycle timing ----------
        wr(16'hF000, 32'd1);               // lands at P0, counter 0
        repeat (5) @(negedge clk);
        rd(16'hF014, v0, v2);
        chk(v0 == 32'd5, "R10 count reaches A", v0, 32'd5);
        rd(16'hF004, v0, v2);
        chk(v0 == 32'd0, "R1 not yet set", v0, 32'd0);
        @(negedge clk);
        rd(16'hF014, v0, v2);
        chk(v0 == 32'd0, "R10 wrap to zero", v0, 32'd0);
        rd(16'hF004, v0, v2);
        chk(v0 == 32'd1, "R1 set on hit edge", v0, 32'd1);
        chk(irq0 == 1'b1, "R9 irq high", {31'd0, irq0}, 32'd1);

        // ---------- R8 hit wins over clear ----------
        wr(16'hF000, 32'd0);
        wr(16'hF004, 32'd0);
        rd(16'hF004, v0, v2);
        chk(v0 == 32'd0 && irq0 == 1'b0, "R9 irq low after clear", {27'd0, irq0, v0[3:0]}, 32'd0);
        wr(16'hF000, 32'd1);
        repeat (4) @(negedge clk);
        wr(16'hF004, 32'd0);               // lands on the hit edge
        rd(16'hF004, v0, v2);
        chk(v0 == 32'd1, "R8 hit beats clear", v0, 32'd1);
        chk(stat0 == 4'h1, "R9 stat_o mirrors", {28'd0, stat0}, 32'd1);

        // ---------- R5 reset mid-run ----------
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(16'hF004, v0, v2);
        chk(v0 == 32'd0, "R5 status after reset", v0, 32'd0);
        rd(16'hF000, v0, v2);
        chk(v0 == 32'd0, "R5 state after reset", v0, 32'd0);
        rd(16'hF008, v0, v2);
        chk(v0 == 32'd0, "R5 compare after reset", v0, 32'd0);

        // ---------- channel 2 flag set (R6, R3, R7) ----------
        wr(16'hF208, 32'd5);
        wr(16'hF20C, 32'd3);
        wr(16'hF210, 32'd7);
        rd(16'hF208, v0, v2);
        chk(v2 == 32'd5 && v0 == 32'd0, "R7 ch2 window", v2, 32'd5);
        rd(16'hF008, v0, v2);
        chk(v0 == 32'd0, "R7 ch0 untouched", v0, 32'd0);
        wr(16'hF200, 32'd2);
        repeat (10) @(negedge clk);
        rd(16'hF204, v0, v2);
        chk(v2 == 32'd0 && irq2 == 1'b0, "R6 ch2 pulse bits absent", v2, 32'd0);
        wr(16'hF200, 32'd3);
        repeat (12) @(negedge clk);
        rd(16'hF204, v0, v2);
        chk(v2 == 32'h8, "R3 ch2 watchdog bit3", v2, 32'h8);
        chk(irq2 == 1'b1 && irq0 == 1'b0, "R9 ch2 irq", {30'd0, irq2, irq0}, 32'h2);
        wr(16'hF200, 32'd0);
        wr(16'hF204, 32'h0);
        rd(16'hF204, v0, v2);
        chk(v2 == 32'd0 && irq2 == 1'b0, "R4 ch2 clear", v2, 32'd0);
        wr(16'hF200, 32'd1);
        repeat (10) @(negedge clk);
        rd(16'hF204, v0, v2);
        chk(v2 == 32'h1, "R1 ch2 interval", v2, 32'h1);

        finish_run();
    end

endmodule